// File: doc/BRIEF.md
# FIFO Depth-Chain and Half-Full Control

This block is the ownership and flag logic that sits beside the storage of one FIFO instance. Several instances can be wired into a ring so that together they act as one deeper queue. Write ownership and read ownership each travel around the ring as a token. A device that holds the write token accepts writes. When it fills its highest location, it passes the token on with a one-cycle low pulse on its write-expansion output. Reads follow the same scheme with the read token and the read-expansion output. One strap marks the device that starts out holding both tokens.

The block latches its mode from the expansion inputs while reset is held. When both inputs are high, the block runs in chain mode. This is their idle level when they are fed from neighbouring devices. When either input is tied low, the block runs as a stand-alone device. It then always holds both tokens, and its write-expansion output becomes an active-low half-full flag. This flag is computed directly from the write and read pointers, so it falls on the write edge and rises on the read edge. The block produces the storage addresses and the accepted-operation strobes. The storage array itself is outside it.

Top module: `fifo_depth_chain`

## Requirements
- R1: While `rst_n` is low, the block samples the expansion inputs on each clock edge. If `wx_in_n` and `rx_in_n` are both high, the block enters chain mode. Otherwise it enters single mode, and in single mode `wxo_hf_n` carries the half-full flag instead of pulses.
- R2: After reset, both pointers are 0 and both outputs `wxo_hf_n` and `rxo_n` are high. In chain mode, a device with `first_ld_n` low holds both tokens, and a device with `first_ld_n` high holds neither.
- R3: In chain mode, a write or read enable is honoured only when the device holds that token or sees the incoming pulse for it in that cycle. Otherwise the grant stays low and the pointer does not move.
- R4: In chain mode, a granted write to location DEPTH-1 releases the write token. The same write drives `wxo_hf_n` low for exactly one `wclk` cycle.
- R5: In chain mode, a granted read from location DEPTH-1 releases the read token. The same read drives `rxo_n` low for exactly one `rclk` cycle.
- R6: An incoming pulse, sampled low on an edge, gives the device the token from then on. The device may also use the token in the very cycle the pulse is present, so a hand-over costs no idle cycle.
- R7: In single mode, both tokens are always held, whatever the value of `first_ld_n`, and `rxo_n` stays high.
- R8: In single mode, `wxo_hf_n` is low when the write pointer minus the read pointer exceeds DEPTH/2, and high when the difference is DEPTH/2 or less. The flag has no register stage, so it changes directly after the write or read edge.
- R9: `wr_addr` and `rd_addr` advance by one for each granted operation and wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, held for at least one edge of each clock |
| first_ld_n | input | 1 | Strap, low on the device that owns both tokens after reset |
| wx_in_n | input | 1 | Write token pulse from the previous device, or tied low for single mode |
| rx_in_n | input | 1 | Read token pulse from the previous device, or tied low for single mode |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_grant | output | 1 | Write accepted on the coming `wclk` edge |
| rd_grant | output | 1 | Read accepted on the coming `rclk` edge |
| wr_addr | output | $clog2(DEPTH) | Storage write address |
| rd_addr | output | $clog2(DEPTH) | Storage read address |
| wxo_hf_n | output | 1 | Write token pulse out (chain mode), or half-full flag, active low (single mode) |
| rxo_n | output | 1 | Read token pulse out |

## Verification
The bench puts a stand-alone device through the exact half-full threshold in both directions and past both pointer wraps. A flag that is off by one would fall on the wrong write. A design that pulsed in single mode would show a spurious low on either output. A ring of three devices receives back-to-back writes across a hand-over, which would expose a dead cycle or a double owner. It also receives writes with an idle gap after a pulse, which would expose a token that is lost when no write follows at once. Each pulse is checked to return high after one edge. The token is followed around the whole ring back to the first device.

// File: rtl/fifo_depth_chain_pkg.sv
// Package: shared types for the depth-chain control block.
// Assumes nothing beyond IEEE 1800-2017.
package fifo_depth_chain_pkg;

    // Operating mode latched during reset.
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_CHAIN  = 1'b1
    } chain_mode_e;

endpackage

// File: rtl/fdc_token_side.sv
// Module: one side (write or read) of the depth-chain control.
// Holds the ownership token, the address pointer (with a wrap bit) and the
// outgoing hand-over pulse for one clock domain.
// Assumes: DEPTH is a power of two and at least 2; rst_n is synchronous to clk
// and held for at least one edge; pulse_in_n is a registered signal from a
// neighbour in the same clock domain.
module fdc_token_side
    import fifo_depth_chain_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          first_n,
    input  logic          mode_sense,
    input  logic          pulse_in_n,
    input  logic          en,
    output chain_mode_e   mode_o,
    output logic          grant,
    output logic [PW-1:0] ptr,
    output logic          pulse_out_n
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    chain_mode_e   mode_q;
    logic          tok_q;
    logic [PW-1:0] ptr_q;
    logic          pulse_q;
    logic          is_chain;
    logic          at_last;
    logic          held;

    // Decode of the current mode, the last-location test and effective ownership.
    always_comb begin
        is_chain = (mode_q == MODE_CHAIN);
        at_last  = (ptr_q[AW-1:0] == LAST);
        held     = !is_chain || tok_q || !pulse_in_n;
        grant    = en && held;
    end

    // Token, pointer, mode latch and one-cycle hand-over pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= mode_sense ? MODE_CHAIN : MODE_SINGLE;
            tok_q   <= !first_n;
            ptr_q   <= '0;
            pulse_q <= 1'b1;
        end else begin
            pulse_q <= 1'b1;
            if (grant) begin
                ptr_q <= ptr_q + PW'(1);
            end
            if (is_chain && grant && at_last) begin
                tok_q   <= 1'b0;
                pulse_q <= 1'b0;
            end else if (is_chain && !pulse_in_n) begin
                tok_q <= 1'b1;
            end
        end
    end

    assign mode_o      = mode_q;
    assign ptr         = ptr_q;
    assign pulse_out_n = pulse_q;

endmodule

// File: rtl/fdc_half_full.sv
// Module: unregistered half-full flag, active low.
// Compares the wrapped difference of the two pointers against DEPTH/2.
// Assumes: both pointers carry one wrap bit above the address; the user never
// writes into a full or reads from an empty store. The output mixes two clock
// domains on purpose and must be treated as asynchronous.
module fdc_half_full #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic [PW-1:0] wptr,
    input  logic [PW-1:0] rptr,
    output logic          hf_n
);

    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

    logic [PW-1:0] fill;

    // Occupancy and threshold compare.
    always_comb begin
        fill = wptr - rptr;
        hf_n = !(fill > HALF);
    end

endmodule

// File: rtl/fifo_depth_chain.sv
// Module: depth-chain and half-full control for one FIFO instance (top).
// Passes write and read tokens round a ring of devices, or in single mode
// turns the write-expansion output into an asynchronous half-full flag.
// Assumes: DEPTH is a power of two and at least 2; reset covers at least one
// edge of each clock; the user does not overfill or underflow the store.
module fifo_depth_chain
    import fifo_depth_chain_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          first_ld_n,
    input  logic          wx_in_n,
    input  logic          rx_in_n,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_grant,
    output logic          rd_grant,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          wxo_hf_n,
    output logic          rxo_n
);

    chain_mode_e   mode_w;
    chain_mode_e   mode_r;
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          w_pulse_n;
    logic          r_pulse_n;
    logic          hf_n;
    logic          sense;
    logic          chain_w;
    logic          chain_r;

    // Chain mode needs both expansion inputs idle high during reset.
    assign sense = wx_in_n && rx_in_n;

    fdc_token_side #(.DEPTH(DEPTH)) u_wside (
        .clk         (wclk),
        .rst_n       (rst_n),
        .first_n     (first_ld_n),
        .mode_sense  (sense),
        .pulse_in_n  (wx_in_n),
        .en          (wr_en),
        .mode_o      (mode_w),
        .grant       (wr_grant),
        .ptr         (wptr),
        .pulse_out_n (w_pulse_n)
    );

    fdc_token_side #(.DEPTH(DEPTH)) u_rside (
        .clk         (rclk),
        .rst_n       (rst_n),
        .first_n     (first_ld_n),
        .mode_sense  (sense),
        .pulse_in_n  (rx_in_n),
        .en          (rd_en),
        .mode_o      (mode_r),
        .grant       (rd_grant),
        .ptr         (rptr),
        .pulse_out_n (r_pulse_n)
    );

    fdc_half_full #(.DEPTH(DEPTH)) u_hf (
        .wptr (wptr),
        .rptr (rptr),
        .hf_n (hf_n)
    );

    // Output selection between hand-over pulse and half-full flag.
    always_comb begin
        chain_w  = (mode_w == MODE_CHAIN);
        chain_r  = (mode_r == MODE_CHAIN);
        wxo_hf_n = chain_w ? w_pulse_n : hf_n;
        rxo_n    = r_pulse_n;
        wr_addr  = wptr[AW-1:0];
        rd_addr  = rptr[AW-1:0];
    end

endmodule

// File: rtl/fifo_depth_chain_chk.sv
// Module: property checker for fifo_depth_chain, attached by bind below.
// Assumes: the same DEPTH as the bound instance.
module fifo_depth_chain_chk #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_grant,
    input logic          rd_grant,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] rd_addr,
    input logic          wxo_hf_n,
    input logic          rxo_n,
    input logic          chain_w,
    input logic          chain_r
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // R3: no grant, no pointer movement.
    a_r3_wr_hold: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_grant |=> $stable(wr_addr));

    // R9: each granted write advances the address by one, modulo DEPTH.
    a_r9_wr_step: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_grant |=> (wr_addr == $past(wr_addr) + AW'(1)));

    // R9: same for reads.
    a_r9_rd_step: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_grant |=> (rd_addr == $past(rd_addr) + AW'(1)));

    // R4: a last-location write in chain mode produces a pulse.
    a_r4_wpulse_at_last: assert property (@(posedge wclk) disable iff (!rst_n)
        (chain_w && wr_grant && wr_addr == LAST) |=> !wxo_hf_n);

    // R4: the write pulse lasts one cycle.
    a_r4_wpulse_one_cycle: assert property (@(posedge wclk) disable iff (!rst_n)
        (chain_w && !wxo_hf_n) |=> wxo_hf_n);

    // R5: the read pulse lasts one cycle.
    a_r5_rpulse_one_cycle: assert property (@(posedge rclk) disable iff (!rst_n)
        !rxo_n |=> rxo_n);

    // R7: single mode keeps the read output idle.
    a_r7_single_rxo: assert property (@(posedge rclk) disable iff (!rst_n)
        !chain_r |-> rxo_n);

endmodule

bind fifo_depth_chain fifo_depth_chain_chk #(.DEPTH(DEPTH)) u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst_n    (rst_n),
    .wr_grant (wr_grant),
    .rd_grant (rd_grant),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .wxo_hf_n (wxo_hf_n),
    .rxo_n    (rxo_n),
    .chain_w  (chain_w),
    .chain_r  (chain_r)
);

// File: tb/sim_fifo_depth_chain.sv
// Bench: one stand-alone device (u0) walked through a vector table, then a
// ring of three chained devices (u1..u3) driven with directed sequences.
module sim_fifo_depth_chain;

    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int NV    = 15;

    // Vector fields: {wr, rd, expected hf_n, expected wr_addr, expected rd_addr}
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 3'd1, 3'd0},
        {1'b1, 1'b0, 1'b1, 3'd2, 3'd0},
        {1'b1, 1'b0, 1'b1, 3'd3, 3'd0},
        {1'b1, 1'b0, 1'b1, 3'd4, 3'd0},
        {1'b1, 1'b0, 1'b0, 3'd5, 3'd0},
        {1'b0, 1'b1, 1'b1, 3'd5, 3'd1},
        {1'b1, 1'b1, 1'b1, 3'd6, 3'd2},
        {1'b1, 1'b0, 1'b0, 3'd7, 3'd2},
        {1'b1, 1'b0, 1'b0, 3'd0, 3'd2},
        {1'b0, 1'b1, 1'b0, 3'd0, 3'd3},
        {1'b0, 1'b1, 1'b1, 3'd0, 3'd4},
        {1'b0, 1'b1, 1'b1, 3'd0, 3'd5},
        {1'b0, 1'b1, 1'b1, 3'd0, 3'd6},
        {1'b0, 1'b1, 1'b1, 3'd0, 3'd7},
        {1'b0, 1'b1, 1'b1, 3'd0, 3'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    // Single device
    logic          s_wr = 1'b0, s_rd = 1'b0;
    logic          s_wg, s_rg, s_hf, s_rxo;
    logic [AW-1:0] s_wa, s_ra;

    fifo_depth_chain #(.DEPTH(DEPTH)) u0 (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .first_ld_n(1'b1),
        .wx_in_n(1'b0), .rx_in_n(1'b0), .wr_en(s_wr), .rd_en(s_rd),
        .wr_grant(s_wg), .rd_grant(s_rg), .wr_addr(s_wa), .rd_addr(s_ra),
        .wxo_hf_n(s_hf), .rxo_n(s_rxo)
    );

    // Ring of three; bus enables shared by all members
    logic          c_wr = 1'b0, c_rd = 1'b0;
    logic [2:0]    wxo, rxo, wg, rg;
    logic [AW-1:0] wa [3];
    logic [AW-1:0] ra [3];

    fifo_depth_chain #(.DEPTH(DEPTH)) u1 (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .first_ld_n(1'b0),
        .wx_in_n(wxo[2]), .rx_in_n(rxo[2]), .wr_en(c_wr), .rd_en(c_rd),
        .wr_grant(wg[0]), .rd_grant(rg[0]), .wr_addr(wa[0]), .rd_addr(ra[0]),
        .wxo_hf_n(wxo[0]), .rxo_n(rxo[0])
    );
    fifo_depth_chain #(.DEPTH(DEPTH)) u2 (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .first_ld_n(1'b1),
        .wx_in_n(wxo[0]), .rx_in_n(rxo[0]), .wr_en(c_wr), .rd_en(c_rd),
        .wr_grant(wg[1]), .rd_grant(rg[1]), .wr_addr(wa[1]), .rd_addr(ra[1]),
        .wxo_hf_n(wxo[1]), .rxo_n(rxo[1])
    );
    fifo_depth_chain #(.DEPTH(DEPTH)) u3 (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .first_ld_n(1'b1),
        .wx_in_n(wxo[1]), .rx_in_n(rxo[1]), .wr_en(c_wr), .rd_en(c_rd),
        .wr_grant(wg[2]), .rd_grant(rg[2]), .wr_addr(wa[2]), .rd_addr(ra[2]),
        .wxo_hf_n(wxo[2]), .rxo_n(rxo[2])
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 reset state
        check("R2 u0 hf_n", int'(s_hf), 1);
        check("R2 u0 addrs", int'({s_wa, s_ra}), 0);
        check("R2 chain wxo idle", int'(wxo), 7);
        check("R2 chain rxo idle", int'(rxo), 7);

        // R7, R8, R9 vector walk on the single device
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            s_wr = VEC[i][8];
            s_rd = VEC[i][7];
            #1;
            check("R7 single write grant", int'(s_wg), int'(VEC[i][8]));
            check("R7 single read grant", int'(s_rg), int'(VEC[i][7]));
            @(posedge clk); #1;
            check("R8 half-full", int'(s_hf), int'(VEC[i][6]));
            check("R9 write addr", int'(s_wa), int'(VEC[i][5:3]));
            check("R9 read addr", int'(s_ra), int'(VEC[i][2:0]));
            check("R7 single rxo idle", int'(s_rxo), 1);
        end
        @(negedge clk);
        s_wr = 1'b0;
        s_rd = 1'b0;

        // R1/R3/R4/R6 writes round the ring, gap after the second hand-over
        for (int k = 0; k < 3 * DEPTH; k++) begin
            int o;
            o = k / DEPTH;
            if (k == 2 * DEPTH) begin
                @(negedge clk);
                c_wr = 1'b0;
                @(posedge clk); #1;
                check("R4 pulse ended during gap", int'(wxo), 7);
            end
            @(negedge clk);
            c_wr = 1'b1;
            #1;
            check("R3 R6 write owner", int'(wg), 1 << o);
            check("R9 owner write addr", int'(wa[o]), k % DEPTH);
            @(posedge clk); #1;
            if (k % DEPTH == DEPTH - 1)
                check("R4 write pulse", int'(wxo), 7 & ~(1 << o));
            else
                check("R1 R4 no write pulse", int'(wxo), 7);
        end
        @(negedge clk);
        c_wr = 1'b0;

        // R5 reads round the ring
        for (int k = 0; k < 3 * DEPTH; k++) begin
            int o;
            o = k / DEPTH;
            @(negedge clk);
            c_rd = 1'b1;
            #1;
            check("R3 R6 read owner", int'(rg), 1 << o);
            check("R9 owner read addr", int'(ra[o]), k % DEPTH);
            @(posedge clk); #1;
            if (k % DEPTH == DEPTH - 1)
                check("R5 read pulse", int'(rxo), 7 & ~(1 << o));
            else
                check("R5 no read pulse", int'(rxo), 7);
        end
        @(negedge clk);
        c_rd = 1'b0;
        @(posedge clk); #1;
        check("R5 read pulse one cycle", int'(rxo), 7);

        // R6 token back at the first device after a full lap
        @(negedge clk);
        c_wr = 1'b1;
        #1;
        check("R6 ring wrap owner", int'(wg), 1);
        check("R9 ring wrap addr", int'(wa[0]), 0);
        @(negedge clk);
        c_wr = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule